// File: doc/BRIEF.md
# Reloadable Baud Clock Generator

This block produces the bit clock for one serial channel. A 12-bit reload value sets the divide ratio. A 12-bit down counter steps once on every cycle in which the count enable is high. When the counter passes zero it reloads itself and emits a one-cycle underflow pulse. A divide-by-two toggle stage turns that pulse train into a serial clock with a 50% duty cycle.

Software reaches the block through a byte-wide register port. The register map has five addresses:

- Address 0 holds the low eight bits of the reload value.
- Address 1 holds reload bits 11:8 in its low nibble.
- Address 2 is the control register. Bit 0 is the run bit.
- Address 3 holds the low eight bits of the counter.
- Address 4 holds counter bits 11:8 in its low nibble.

Setting the run bit from 0 to 1 copies the reload value into the counter and clears the toggle stage. Clearing the run bit freezes the counter and parks the clock low.

With a reload value N and the count enable held high, the underflow period is N+1 cycles. The serial clock period is therefore 2(N+1) cycles.

Top module: `baud_clk_gen`

## Requirements
- R1: While rst_ni is low, all of the following hold: every register reads 0, uflow_o is 0 and sclk_o is 0.
- R2: A write to address 0 sets reload bits 7:0. A write to address 1 sets reload bits 11:8 from wdata bits 3:0. When address 1 is read, bits 7:4 return 0.
- R3: The counter is loaded from the reload register when the run bit (address 2, bit 0) changes from 0 to 1. The loaded value can be read on the edge that performs the write.
- R4: While running with the count enable high, the counter steps N, N-1, ..., 0. On the next enabled step it reloads N, and uflow_o is high for the cycle that follows that edge. The underflow period is N+1 cycles.
- R5: sclk_o changes level on every underflow and is low just after a start. This gives a period of 2(N+1) cycles.
- R6: The counter does not step while cnt_en_i is low. No underflow occurs and sclk_o holds its level.
- R7: Writing 0 to the run bit stops the block. The counter holds its value, sclk_o goes low and uflow_o stays low. A later start reloads the counter.
- R8: Writing the reload register while running does not change the current count. The new value is used from the next underflow. If the write lands on the same edge as an underflow, the counter takes the old reload value.
- R9: Writing 1 to the run bit while it is already 1 does not reload the counter. Counting continues.
- R10: Addresses 3 and 4 read the live counter, and bits 7:4 of address 4 read 0. A write to either address presets that part of the counter.
- R11: Address 2 reads the run bit in bit 0 and 0 in all other bits. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable; the counter steps on cycles where it is high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the addressed register (combinational) |
| uflow_o | output | 1 | One-cycle underflow pulse |
| sclk_o | output | 1 | Serial clock, 50% duty cycle |

## Verification
Two cases need care because two events fall on the same clock edge.

The first is a reload-register write that lands on the edge where the counter passes zero. The bench provokes it by issuing the write exactly N+1 enabled cycles after the previous underflow. It then checks three things: the counter holds the old reload value, the register reads back the new value, and the following underflow period uses the new value.

The second is a control write on an edge where the counter would step. A start while already running must leave the count stepping by one, not reload it. A stop must freeze the count and must not let an underflow or a clock edge escape.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_RLD_LO = 3'd0,
    ADR_RLD_HI = 3'd1,
    ADR_CTRL   = 3'd2,
    ADR_CNT_LO = 3'd3,
    ADR_CNT_HI = 3'd4
  } reg_adr_e;

  typedef struct packed {
    logic rld_lo;
    logic rld_hi;
    logic ctrl;
    logic cnt_lo;
    logic cnt_hi;
  } wr_sel_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              run_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              cnt_wr_lo_o,
  output logic              cnt_wr_hi_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  wr_sel_t          sel;
  logic [CNT_W-1:0] reload_q;
  logic             run_q;

  always_comb begin
    sel = '0;
    if (we_i) begin
      unique case (addr_i)
        ADR_RLD_LO: sel.rld_lo = 1'b1;
        ADR_RLD_HI: sel.rld_hi = 1'b1;
        ADR_CTRL:   sel.ctrl   = 1'b1;
        ADR_CNT_LO: sel.cnt_lo = 1'b1;
        ADR_CNT_HI: sel.cnt_hi = 1'b1;
        default:    sel        = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      run_q    <= 1'b0;
    end else begin
      if (sel.rld_lo) reload_q[DATA_W-1:0]     <= wdata_i;
      if (sel.rld_hi) reload_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
      if (sel.ctrl)   run_q                    <= wdata_i[0];
    end
  end

  // start fires only on a 0->1 transition of run
  assign start_o     = sel.ctrl & wdata_i[0] & ~run_q;
  assign stop_o      = sel.ctrl & ~wdata_i[0];
  assign cnt_wr_lo_o = sel.cnt_lo;
  assign cnt_wr_hi_o = sel.cnt_hi;
  assign reload_o    = reload_q;
  assign run_o       = run_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_RLD_LO: rdata_o             = reload_q[DATA_W-1:0];
      ADR_RLD_HI: rdata_o[HI_W-1:0]   = reload_q[CNT_W-1:DATA_W];
      ADR_CTRL:   rdata_o[0]          = run_q;
      ADR_CNT_LO: rdata_o             = cnt_i[DATA_W-1:0];
      ADR_CNT_HI: rdata_o[HI_W-1:0]   = cnt_i[CNT_W-1:DATA_W];
      default:    rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              uf_evt_o,
  output logic              uf_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic             uf_q;
  logic             step;
  logic             zero;

  // start, stop and presets take the edge; no step in that cycle
  assign step     = run_i & en_i & ~start_i & ~stop_i & ~wr_lo_i & ~wr_hi_i;
  assign zero     = (cnt_q == '0);
  assign uf_evt_o = step & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= uf_evt_o;
      if (start_i) begin
        cnt_q <= reload_i;
      end else if (wr_lo_i || wr_hi_i) begin
        if (wr_lo_i) cnt_q[DATA_W-1:0]     <= wdata_i;
        if (wr_hi_i) cnt_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
      end else if (step) begin
        cnt_q <= zero ? reload_i : cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf_q;
endmodule

// File: rtl/baud_toggle.sv
module baud_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgl_i,
  output logic sclk_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= 1'b0;
    else if (clr_i) lvl_q <= 1'b0;
    else if (tgl_i) lvl_q <= ~lvl_q;
  end

  assign sclk_o = lvl_q;
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              uflow_o,
  output logic              sclk_o
);
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_w;
  logic             run_w;
  logic             start_w;
  logic             stop_w;
  logic             wr_lo_w;
  logic             wr_hi_w;
  logic             uf_evt_w;
  logic             cnt_wr_w;

  assign cnt_wr_w = wr_lo_w | wr_hi_w;

  baud_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cnt_i       (cnt_w),
    .reload_o    (reload_w),
    .run_o       (run_w),
    .start_o     (start_w),
    .stop_o      (stop_w),
    .cnt_wr_lo_o (wr_lo_w),
    .cnt_wr_hi_o (wr_hi_w),
    .rdata_o     (reg_rdata_o)
  );

  baud_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .start_i  (start_w),
    .stop_i   (stop_w),
    .en_i     (cnt_en_i),
    .reload_i (reload_w),
    .wr_lo_i  (wr_lo_w),
    .wr_hi_i  (wr_hi_w),
    .wdata_i  (reg_wdata_i),
    .cnt_o    (cnt_w),
    .uf_evt_o (uf_evt_w),
    .uf_o     (uflow_o)
  );

  baud_toggle u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_w | stop_w),
    .tgl_i  (uf_evt_w),
    .sclk_o (sclk_o)
  );
endmodule

// File: rtl/baud_clk_gen_chk.sv
module baud_clk_gen_chk
  import baud_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              cnt_wr,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              uflow_o,
  input logic              sclk_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> cnt_q == $past(reload_q));  // R3

  AST_UF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |-> (run_q && cnt_q == $past(reload_q)));  // R4

  AST_SCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |-> sclk_o != $past(sclk_o));  // R5

  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!sclk_o && !uflow_o));  // R7

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !$past(run_q) && !$past(cnt_wr)) |-> cnt_q == $past(cnt_q));  // R7

  AST_CNT_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADR_CNT_HI) |-> reg_rdata_o[DATA_W-1:HI_W] == '0);  // R10
endmodule

bind baud_clk_gen baud_clk_gen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_q       (run_w),
  .cnt_q       (cnt_w),
  .reload_q    (reload_w),
  .cnt_wr      (cnt_wr_w),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .uflow_o     (uflow_o),
  .sclk_o      (sclk_o)
);

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       uflow_o;
  logic       sclk_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [2:0] A_RLO = 3'd0, A_RHI = 3'd1, A_CTL = 3'd2,
                         A_CLO = 3'd3, A_CHI = 3'd4, A_BAD = 3'd7;

  // {we, addr, wdata, expected read}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, A_RLO, 8'hA5, 8'h00},
    {1'b0, A_RLO, 8'h00, 8'hA5},  // R2
    {1'b1, A_RHI, 8'hFF, 8'h00},
    {1'b0, A_RHI, 8'h00, 8'h0F},  // R2
    {1'b1, A_CLO, 8'h3C, 8'h00},
    {1'b0, A_CLO, 8'h00, 8'h3C},  // R10
    {1'b1, A_CHI, 8'hF9, 8'h00},
    {1'b0, A_CHI, 8'h00, 8'h09},  // R10
    {1'b0, A_CTL, 8'h00, 8'h00},  // R11
    {1'b1, A_CTL, 8'hFE, 8'h00},
    {1'b0, A_CTL, 8'h00, 8'h00},  // R11
    {1'b1, A_BAD, 8'h77, 8'h00},
    {1'b0, A_BAD, 8'h00, 8'h00},  // R11
    {1'b0, A_RLO, 8'h00, 8'hA5}   // R11 unmapped write left reload alone
  };

  baud_clk_gen u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_en_i    (cnt_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .uflow_o     (uflow_o),
    .sclk_o      (sclk_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, {8'h00, reg_rdata_o}, {8'h00, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 sclk", {15'd0, sclk_o}, 16'd0);
    chk("R1 uflow", {15'd0, uflow_o}, 16'd0);
    rd("R1 reload", A_RLO, 8'h00);
    rd("R1 cnt", A_CLO, 8'h00);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rd("R2/R10/R11 table", VEC[i][18:16], VEC[i][7:0]);
    end

    // N = 3, continuous enable
    wr(A_RLO, 8'h03);
    wr(A_RHI, 8'h00);
    cnt_en_i = 1'b1;
    wr(A_CTL, 8'h01);
    rd("R3 load", A_CLO, 8'h03);
    chk("R5 start low", {15'd0, sclk_o}, 16'd0);
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk_i);
      rd("R4 count", A_CLO, 8'(3 - (k % 4)));
      chk("R4 uflow", {15'd0, uflow_o}, {15'd0, (k % 4) == 0});
      chk("R5 sclk", {15'd0, sclk_o}, {15'd0, ((k / 4) % 2) == 1});
    end

    // R6: hold with enable low
    cnt_en_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rd("R6 hold", A_CLO, 8'h02);
    chk("R6 sclk hold", {15'd0, sclk_o}, 16'd1);
    chk("R6 no uflow", {15'd0, uflow_o}, 16'd0);

    // R7: stop
    wr(A_CTL, 8'h00);
    chk("R7 sclk low", {15'd0, sclk_o}, 16'd0);
    cnt_en_i = 1'b1;
    repeat (6) @(negedge clk_i);
    rd("R7 hold", A_CLO, 8'h02);
    chk("R7 no uflow", {15'd0, uflow_o}, 16'd0);
    rd("R7 run reads 0", A_CTL, 8'h00);

    // R7 restart, R8 reload write mid-count
    wr(A_CTL, 8'h01);
    rd("R7 restart reload", A_CLO, 8'h03);
    wr(A_RLO, 8'h05);
    rd("R8 count undisturbed", A_CLO, 8'h02);
    repeat (3) @(negedge clk_i);
    chk("R8 uflow", {15'd0, uflow_o}, 16'd1);
    rd("R8 new reload used", A_CLO, 8'h05);
    repeat (5) @(negedge clk_i);
    rd("R8 at zero", A_CLO, 8'h00);
    wr(A_RLO, 8'h07);  // lands on the underflow edge
    chk("R8 same-edge uflow", {15'd0, uflow_o}, 16'd1);
    rd("R8 same-edge old value", A_CLO, 8'h05);
    rd("R8 same-edge reg new", A_RLO, 8'h07);
    repeat (6) @(negedge clk_i);
    chk("R8 next uflow", {15'd0, uflow_o}, 16'd1);
    rd("R8 next reload", A_CLO, 8'h07);

    // R9: run 1 -> 1 keeps counting
    wr(A_CTL, 8'h01);
    rd("R9 no reload", A_CLO, 8'h06);
    rd("R11 run reads 1", A_CTL, 8'h01);

    // R1: reset during run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid sclk", {15'd0, sclk_o}, 16'd0);
    chk("R1 mid uflow", {15'd0, uflow_o}, 16'd0);
    rd("R1 mid ctrl", A_CTL, 8'h00);
    rd("R1 mid reload", A_RLO, 8'h00);
    rd("R1 mid cnt", A_CLO, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule